// File: doc/BRIEF.md
# Memory Event Performance Counter Unit

This block keeps a bank of independent event counters (four by default) that observe request traffic to two memories: a control memory (index 0 of every per-memory input vector) and a packet memory (index 1). Each counter is steered by an 8-bit selector. The selector names the memory, the request direction, and an optional transfer-size window. It can also select a latency measurement, free-running cycle counting, or a frozen count. All selectors sit together in one configuration word: byte k of the word drives counter k.

Software writes the configuration word through a single-cycle write strobe and reads it back. One counter at a time is read through a select input. A selector written with its clear bit set zeroes its counter at the write edge. That bit is never stored, so it always reads back as zero.

Each counter slice holds a mode state register with four named states: MODE_REQ (count matching request strobes), MODE_LAT (count cycles with outstanding operations), MODE_CYC (count every clock), and MODE_HOLD (no change). Reset puts every slice in MODE_REQ, because an all-zero selector means "any control-memory request". The only transition is a configuration write. On that write each slice moves to the state decoded from its new event code: MODE_LAT for codes 11000/11001, MODE_CYC for 11111, MODE_HOLD for 11110 and for every reserved code, and MODE_REQ otherwise. With no write, the state stays where it is.

Top module: `mem_perf_counters`

## Requirements
- R1: After reset every counter reads 0 and the configuration word reads 0.
- R2: Byte k of the configuration word (bits 8k+7..8k) is the selector of counter k. Reading the word returns the stored selectors with bits 6 and 5 of each byte as zero.
- R3: A write whose selector byte has bit 6 set makes that counter 0 at the write edge. The new event is counted from the next cycle on, and bit 6 reads back as 0.
- R4: Selector bit 7 chooses the memory: 0 watches the control-memory inputs (index 0) and 1 watches the packet-memory inputs (index 1).
- R5: Request modes use event code bits 4..3 for direction (00 any, 01 read with req_wr=0, 10 write with req_wr=1) and bits 2..0 for size (0 any size, 1: 0-4, 2: 5-8, 3: 9-16, 4: 17-32, 5: 33-64, 6: 65-128 bytes). A request counts only when req_vld is high and the memory, direction and size all match. Sizes above 128 match only size code 0.
- R6: A counter changes by at most one per cycle. It is CNT_W bits wide (32 by default) and wraps from its maximum value to 0.
- R7: Code 11110 and the reserved codes 00111, 01111, 10111, 11010, 11011, 11100 and 11101 leave the counter unchanged.
- R8: Code 11111 adds one every clock cycle.
- R9: Code 11000 (read) or 11001 (write) adds one in each cycle where the selected memory has at least one operation of that direction outstanding. An operation becomes outstanding the cycle after its request and stops being outstanding the cycle after its done strobe. A request in cycle t that completes in cycle t+k therefore adds k.
- R10: A write without bit 6 keeps the count. The old event is still counted in the write cycle, and the new event is counted from the next cycle.
- R11: cnt_rdata shows the counter chosen by cnt_sel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | NUM_CNT*8 | Configuration word to write |
| cfg_rdata | output | NUM_CNT*8 | Stored configuration word |
| cnt_sel | input | $clog2(NUM_CNT) | Counter read select |
| cnt_rdata | output | CNT_W | Selected counter value |
| req_vld | input | 2 | Request strobe per memory (0 control, 1 packet) |
| req_wr | input | 2 | Request direction per memory, 1 = write |
| req_bytes | input | 2*BYTES_W | Byte count per memory, memory m at bits m*BYTES_W upward |
| rd_done | input | 2 | Read completion strobe per memory |
| wr_done | input | 2 | Write completion strobe per memory |

## Verification
The following properties are checked on every cycle:
- A counter never steps by more than one.
- A cleared counter is zero on the next cycle.
- A counter in hold mode stays still.
- A counter in cycle mode always advances.
- A request always leaves its direction marked outstanding on the next cycle.

Some behaviour can only be shown by the directed scenarios:
- That each event code picks the intended memory, direction and size window.
- That a latency span of k cycles adds exactly k.
- That byte positions map to the right counters.
- That a mode change without clear keeps the count.
- That the counter wraps to zero.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    typedef enum logic [1:0] {
        MODE_REQ  = 2'd0,
        MODE_LAT  = 2'd1,
        MODE_CYC  = 2'd2,
        MODE_HOLD = 2'd3
    } mode_e;

    localparam int SEL_W   = 8;
    localparam int NUM_MEM = 2;

    // size window index of a byte count; 7 = beyond every window
    function automatic logic [2:0] size_bucket(input logic [15:0] nbytes);
        logic [2:0] b;
        if (nbytes <= 16'd4)        b = 3'd1;
        else if (nbytes <= 16'd8)   b = 3'd2;
        else if (nbytes <= 16'd16)  b = 3'd3;
        else if (nbytes <= 16'd32)  b = 3'd4;
        else if (nbytes <= 16'd64)  b = 3'd5;
        else if (nbytes <= 16'd128) b = 3'd6;
        else                        b = 3'd7;
        return b;
    endfunction

    function automatic mode_e decode_mode(input logic [4:0] code);
        mode_e m;
        if (code[4:3] == 2'b11) begin
            unique case (code[2:0])
                3'b000, 3'b001: m = MODE_LAT;
                3'b111:         m = MODE_CYC;
                default:        m = MODE_HOLD;
            endcase
        end else if (code[2:0] == 3'b111) begin
            m = MODE_HOLD;
        end else begin
            m = MODE_REQ;
        end
        return m;
    endfunction

endpackage

// File: rtl/mpc_pending.sv
module mpc_pending #(
    parameter int OUT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic done,
    output logic busy
);
    localparam logic [OUT_W-1:0] OUT_MAX = {OUT_W{1'b1}};

    logic [OUT_W-1:0] outst_q;
    logic [OUT_W-1:0] outst_d;

    always_comb begin
        outst_d = outst_q;
        if (issue && !done && outst_q != OUT_MAX)
            outst_d = outst_q + 1'b1;
        else if (!issue && done && outst_q != '0)
            outst_d = outst_q - 1'b1;
        else if (issue && done && outst_q == '0)
            outst_d = {{(OUT_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) outst_q <= '0;
        else        outst_q <= outst_d;
    end

    assign busy = (outst_q != '0);

    assert_issue_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> busy);
    assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !issue) |=> !busy);

endmodule

// File: rtl/mpc_slice.sv
module mpc_slice
    import mpc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BYTES_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [NUM_MEM-1:0]           req_vld,
    input  logic [NUM_MEM-1:0]           req_wr,
    input  logic [NUM_MEM*BYTES_W-1:0]   req_bytes,
    input  logic [NUM_MEM-1:0]           busy_rd,
    input  logic [NUM_MEM-1:0]           busy_wr,
    output logic [SEL_W-1:0]             sel_q,
    output logic [CNT_W-1:0]             count_q
);
    localparam logic [SEL_W-1:0] KEEP_MASK = 8'h9F;

    mode_e            mode_q;
    mode_e            mode_d;
    logic             mem;
    logic [4:0]       code;
    logic [15:0]      nbytes;
    logic             dir_ok;
    logic             size_ok;
    logic             inc;
    logic             clr;

    assign mem    = sel_q[7];
    assign code   = sel_q[4:0];
    assign nbytes = 16'(req_bytes[mem*BYTES_W +: BYTES_W]);
    assign clr    = wr_en && wr_sel[6];

    // state transition: only a configuration write moves the mode
    always_comb begin
        mode_d = mode_q;
        if (wr_en) mode_d = decode_mode(wr_sel[4:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_REQ;
            sel_q  <= '0;
        end else begin
            mode_q <= mode_d;
            if (wr_en) sel_q <= wr_sel & KEEP_MASK;
        end
    end

    // output process: increment decision per mode
    always_comb begin
        dir_ok  = (code[4:3] == 2'b00)
               || (code[4:3] == 2'b01 && !req_wr[mem])
               || (code[4:3] == 2'b10 &&  req_wr[mem]);
        size_ok = (code[2:0] == 3'd0) || (code[2:0] == size_bucket(nbytes));
        unique case (mode_q)
            MODE_REQ:  inc = req_vld[mem] && dir_ok && size_ok;
            MODE_LAT:  inc = code[0] ? busy_wr[mem] : busy_rd[mem];
            MODE_CYC:  inc = 1'b1;
            MODE_HOLD: inc = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   count_q <= '0;
        else if (clr) count_q <= '0;
        else if (inc) count_q <= count_q + 1'b1;
    end

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0));
    assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));
    assert_hold_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD && !clr) |=> $stable(count_q));
    assert_cycle_adv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_CYC && !clr) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: rtl/mem_perf_counters.sv
module mem_perf_counters
    import mpc_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int BYTES_W = 8,
    parameter int OUT_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [NUM_CNT*8-1:0]         cfg_wdata,
    output logic [NUM_CNT*8-1:0]         cfg_rdata,
    input  logic [$clog2(NUM_CNT)-1:0]   cnt_sel,
    output logic [CNT_W-1:0]             cnt_rdata,
    input  logic [1:0]                   req_vld,
    input  logic [1:0]                   req_wr,
    input  logic [2*BYTES_W-1:0]         req_bytes,
    input  logic [1:0]                   rd_done,
    input  logic [1:0]                   wr_done
);
    localparam int CFG_W = NUM_CNT * SEL_W;

    logic [NUM_MEM-1:0] busy_rd;
    logic [NUM_MEM-1:0] busy_wr;
    logic [CNT_W-1:0]   counts [NUM_CNT];
    logic [CFG_W-1:0]   sel_all;

    for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
        mpc_pending #(.OUT_W(OUT_W)) u_rd (
            .clk(clk), .rst_n(rst_n),
            .issue(req_vld[m] && !req_wr[m]),
            .done(rd_done[m]),
            .busy(busy_rd[m])
        );
        mpc_pending #(.OUT_W(OUT_W)) u_wr (
            .clk(clk), .rst_n(rst_n),
            .issue(req_vld[m] && req_wr[m]),
            .done(wr_done[m]),
            .busy(busy_wr[m])
        );
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
        mpc_slice #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_slice (
            .clk(clk), .rst_n(rst_n),
            .wr_en(cfg_we),
            .wr_sel(cfg_wdata[k*SEL_W +: SEL_W]),
            .req_vld(req_vld),
            .req_wr(req_wr),
            .req_bytes(req_bytes),
            .busy_rd(busy_rd),
            .busy_wr(busy_wr),
            .sel_q(sel_all[k*SEL_W +: SEL_W]),
            .count_q(counts[k])
        );
    end

    assign cfg_rdata = sel_all;
    assign cnt_rdata = counts[cnt_sel];

endmodule

// File: tb/tb_mem_perf_counters.sv
module tb_mem_perf_counters;
    localparam int CW = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic [1:0]  cnt_sel;
    logic [CW-1:0] cnt_rdata;
    logic [1:0]  req_vld, req_wr, rd_done, wr_done;
    logic [15:0] req_bytes;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mem_perf_counters #(.NUM_CNT(4), .CNT_W(CW), .BYTES_W(8), .OUT_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cnt_sel(cnt_sel), .cnt_rdata(cnt_rdata),
        .req_vld(req_vld), .req_wr(req_wr), .req_bytes(req_bytes),
        .rd_done(rd_done), .wr_done(wr_done)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_cnt(input string req, input int idx, input int exp);
        cnt_sel = 2'(idx);
        #1;
        check(req, longint'(cnt_rdata), longint'(exp));
    endtask

    task automatic idle_inputs();
        cfg_we = 0; cfg_wdata = '0; req_vld = '0; req_wr = '0;
        req_bytes = '0; rd_done = '0; wr_done = '0;
    endtask

    task automatic write_cfg(input logic [31:0] w);
        cfg_we = 1; cfg_wdata = w;
        step();
        cfg_we = 0; cfg_wdata = '0;
    endtask

    // per-cycle request drive: ctrl then packet
    task automatic drive_req(input bit v0, input bit w0, input int b0,
                             input bit v1, input bit w1, input int b1);
        req_vld = {v1, v0}; req_wr = {w1, w0};
        req_bytes = {8'(b1), 8'(b0)};
        step();
        req_vld = '0; req_wr = '0; req_bytes = '0;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 4; i++) check_cnt("R1 counter after reset", i, 0);
        check("R1 config after reset", longint'(cfg_rdata), 0);
    endtask

    task automatic t_layout();
        write_cfg(32'hFFFF_FFFF);
        check("R2 R3 readback masks bits 6 and 5", longint'(cfg_rdata), 32'h9F9F_9F9F);
    endtask

    task automatic t_latency();
        // c0 ctrl read lat, c1 pkt write lat, c2 ctrl write lat, c3 pkt read lat
        write_cfg(32'hD859_D958);
        req_vld = 2'b01; req_wr = 2'b00; step();
        req_vld = 2'b10; req_wr = 2'b10; step();
        req_vld = '0; req_wr = '0; step();
        rd_done = 2'b01; step(); rd_done = '0;
        wr_done = 2'b10; step(); wr_done = '0;
        step(); step();
        check_cnt("R9 ctrl read latency", 0, 3);
        check_cnt("R9 R4 pkt write latency", 1, 3);
        check_cnt("R9 ctrl write latency idle", 2, 0);
        check_cnt("R9 R4 pkt read latency idle", 3, 0);
    endtask

    task automatic t_cycle();
        write_cfg(32'h5E5F_5E5E);
        check("R3 clear bit reads back 0", longint'(cfg_rdata), 32'h1E1F_1E1E);
        for (int i = 0; i < 10; i++) step();
        check_cnt("R8 R2 cycle counter 2", 2, 10);
        check_cnt("R7 R2 hold counter 0", 0, 0);
        check_cnt("R7 R2 hold counter 1", 1, 0);
        check_cnt("R7 R2 hold counter 3", 3, 0);
    endtask

    task automatic t_switch();
        write_cfg(32'h5E5E_5E5F);
        for (int i = 0; i < 5; i++) step();
        check_cnt("R3 R8 count from zero after clear", 0, 5);
        write_cfg(32'h1E1E_1E1E);
        check_cnt("R10 old event counted in write cycle", 0, 6);
        for (int i = 0; i < 4; i++) step();
        check_cnt("R10 hold keeps count", 0, 6);
        write_cfg(32'h1E1E_1E1F);
        for (int i = 0; i < 3; i++) step();
        check_cnt("R10 resume without clear", 0, 9);
        check_cnt("R10 other counter untouched", 1, 0);
    endtask

    task automatic t_requests();
        // c0 ctrl read 5-8B, c1 pkt write any, c2 ctrl any 65-128B, c3 pkt any
        write_cfg(32'hC046_D04A);
        drive_req(1, 0, 6,   1, 1, 200);
        drive_req(1, 0, 8,   0, 0, 0);
        drive_req(1, 0, 9,   0, 0, 0);
        drive_req(1, 1, 100, 1, 0, 4);
        drive_req(1, 0, 128, 1, 1, 5);
        drive_req(1, 0, 5,   0, 0, 0);
        drive_req(0, 0, 6,   0, 0, 0);
        drive_req(1, 1, 129, 0, 0, 0);
        check_cnt("R5 ctrl read 5-8 bytes", 0, 3);
        check_cnt("R5 R4 pkt write any size", 1, 2);
        check_cnt("R5 ctrl any 65-128 bytes", 2, 2);
        check_cnt("R5 R4 pkt any request", 3, 3);
    endtask

    task automatic t_reserved();
        write_cfg(32'h5A57_4F47);
        check("R2 reserved codes stored", longint'(cfg_rdata), 32'h1A17_0F07);
        drive_req(1, 0, 6,   1, 0, 6);
        drive_req(1, 1, 200, 1, 1, 3);
        drive_req(1, 0, 100, 0, 0, 0);
        drive_req(1, 1, 16,  0, 0, 0);
        for (int i = 0; i < 4; i++) check_cnt("R7 reserved code no count", i, 0);
    endtask

    task automatic t_wrap();
        write_cfg(32'h5E5E_5E5F);
        for (int i = 0; i < (1 << CW); i++) step();
        check_cnt("R6 wrap to zero", 0, 0);
        step();
        check_cnt("R6 count after wrap", 0, 1);
    endtask

    task automatic t_readmux();
        write_cfg(32'h5E5E_5E5E);
        write_cfg(32'h5F1E_1E1E);
        step();
        check_cnt("R11 select counter 3", 3, 1);
        check_cnt("R11 select counter 0", 0, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        cnt_sel = '0;
        rst_n = 0;
        step(); step();
        rst_n = 1;
        step();
        t_reset();
        t_layout();
        t_latency();
        t_cycle();
        t_switch();
        t_requests();
        t_reserved();
        t_wrap();
        t_readmux();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule